// File: doc/BRIEF.md
# Circular address generator

This block keeps four sets of pointer state for a processor's data side. Each set holds an index, a modify step, a buffer length and a buffer base, all 32 bits wide. Two request ports can each pick a set in the same cycle. Each port receives that set's current index as a byte address in the flat 32-bit space. The index is then moved on by a step, which is either the set's modify register or an immediate value given with the request. This gives the two addresses a dual data fetch needs in every cycle.

The base and length registers describe a circular buffer. When the moved index runs off either end of the buffer window, it is folded back into the window by one length. A length of zero turns the folding off, and the index then advances linearly.

Software or a sequencer loads the registers through a one-word write port.

Top module: `circAddrGen`

## Requirements
- R1: After reset, every register in every set is zero, both address outputs and both valid outputs are zero, and the conflict output is zero.
- R2: When wrEn is high at a clock edge, wrData is stored into set wrSet in the register chosen by wrKind. The codes are: 0 selects index, 1 selects modify, 2 selects length, 3 selects base.
- R3: A request on port N at a clock edge sets pNValid and loads pNAddr with the selected set's index as it was before that edge. Without a request, pNValid is low and pNAddr keeps its last value.
- R4: With length zero, a request updates the index to index plus step, modulo 2^32.
- R5: With length non-zero, when index plus step is equal to or above base plus length, the new index is index plus step minus length.
- R6: With length non-zero, when index plus step is below base, the new index is index plus step plus length.
- R7: When pNUseImm is high, the step is pNImm. When it is low, the step is the set's modify register.
- R8: Requests on the two ports to different sets update both sets in the same cycle, each set independently.
- R9: When both ports request the same set in one cycle, both outputs carry the same index, the update from port 0 is kept, and conflict is high in the following cycle only.
- R10: A write to an index register at the same edge as a request on that set takes priority over the post-modify update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| wrSet | input | 2 | Register set written |
| wrData | input | 32 | Write value |
| p0Req | input | 1 | Port 0 address request |
| p0Set | input | 2 | Port 0 set select |
| p0UseImm | input | 1 | Port 0 takes its step from p0Imm |
| p0Imm | input | 32 | Port 0 immediate step (two's complement) |
| p1Req | input | 1 | Port 1 address request |
| p1Set | input | 2 | Port 1 set select |
| p1UseImm | input | 1 | Port 1 takes its step from p1Imm |
| p1Imm | input | 32 | Port 1 immediate step (two's complement) |
| p0Addr | output | 32 | Port 0 address |
| p0Valid | output | 1 | Port 0 address valid |
| p1Addr | output | 32 | Port 1 address |
| p1Valid | output | 1 | Port 1 address valid |
| conflict | output | 1 | Both ports updated one set in the previous cycle |

## Verification
The bench builds the block with its default parameters: four sets and 32-bit addresses. With four sets, one set can be kept linear while others wrap upward, wrap downward, or are shared by both ports. The full 32-bit width lets a linear step cross the top of the address space and come back to low addresses. The buffer windows are chosen so that an update lands exactly on base plus length, and a negative step drops just below base.

// File: rtl/circ_pkg.sv
package circ_pkg;

  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_BASE = 2'd3
  } regKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic req0;
    logic req1;
    logic upd0;
    logic upd1;
    logic wrStb;
    logic clash;
  } ctrlStb_t;

endpackage

// File: rtl/circCtrl.sv
module circCtrl
  import circ_pkg::*;
#(
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             p0Req,
  input  logic [SET_W-1:0] p0Set,
  input  logic             p1Req,
  input  logic [SET_W-1:0] p1Set,
  output ctrlStb_t         stb,
  output logic             p0Valid,
  output logic             p1Valid,
  output logic             conflict
);

  logic clash;

  assign clash = p0Req && p1Req && (p0Set == p1Set);

  always_comb begin
    stb.req0  = p0Req;
    stb.req1  = p1Req;
    stb.upd0  = p0Req;
    stb.upd1  = p1Req && !clash;
    stb.wrStb = wrEn;
    stb.clash = clash;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p0Valid  <= 1'b0;
      p1Valid  <= 1'b0;
      conflict <= 1'b0;
    end else begin
      p0Valid  <= p0Req;
      p1Valid  <= p1Req;
      conflict <= clash;
    end
  end

endmodule

// File: rtl/circDatapath.sv
module circDatapath
  import circ_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int ADDR_W   = 32,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [1:0]        wrKind,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [SET_W-1:0]  p0Set,
  input  logic              p0UseImm,
  input  logic [ADDR_W-1:0] p0Imm,
  input  logic [SET_W-1:0]  p1Set,
  input  logic              p1UseImm,
  input  logic [ADDR_W-1:0] p1Imm,
  output logic [ADDR_W-1:0] p0Addr,
  output logic [ADDR_W-1:0] p1Addr
);

  logic [ADDR_W-1:0] idxR  [NUM_SETS];
  logic [ADDR_W-1:0] modR  [NUM_SETS];
  logic [ADDR_W-1:0] lenR  [NUM_SETS];
  logic [ADDR_W-1:0] baseR [NUM_SETS];

  logic [ADDR_W-1:0] step0, step1, next0, next1;

  function automatic logic [ADDR_W-1:0] wrapNext(
    input logic [ADDR_W-1:0] idx,
    input logic [ADDR_W-1:0] stp,
    input logic [ADDR_W-1:0] len,
    input logic [ADDR_W-1:0] base
  );
    logic [ADDR_W-1:0] sum, lim;
    sum = idx + stp;
    lim = base + len;
    if (len == '0)       return sum;
    else if (sum >= lim) return sum - len;
    else if (sum < base) return sum + len;
    else                 return sum;
  endfunction

  assign step0 = p0UseImm ? p0Imm : modR[p0Set];
  assign step1 = p1UseImm ? p1Imm : modR[p1Set];
  assign next0 = wrapNext(idxR[p0Set], step0, lenR[p0Set], baseR[p0Set]);
  assign next1 = wrapNext(idxR[p1Set], step1, lenR[p1Set], baseR[p1Set]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        idxR[s]  <= '0;
        modR[s]  <= '0;
        lenR[s]  <= '0;
        baseR[s] <= '0;
      end
      p0Addr <= '0;
      p1Addr <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (stb.wrStb && wrSet == SET_W'(s) && wrKind == KIND_IDX)
          idxR[s] <= wrData;
        else if (stb.upd0 && p0Set == SET_W'(s))
          idxR[s] <= next0;
        else if (stb.upd1 && p1Set == SET_W'(s))
          idxR[s] <= next1;
        if (stb.wrStb && wrSet == SET_W'(s) && wrKind == KIND_MOD)  modR[s]  <= wrData;
        if (stb.wrStb && wrSet == SET_W'(s) && wrKind == KIND_LEN)  lenR[s]  <= wrData;
        if (stb.wrStb && wrSet == SET_W'(s) && wrKind == KIND_BASE) baseR[s] <= wrData;
      end
      if (stb.req0) p0Addr <= idxR[p0Set];
      if (stb.req1) p1Addr <= idxR[p1Set];
    end
  end

endmodule

// File: rtl/circAddrGen.sv
module circAddrGen
  import circ_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int ADDR_W   = 32,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              p0Req,
  input  logic [SET_W-1:0]  p0Set,
  input  logic              p0UseImm,
  input  logic [ADDR_W-1:0] p0Imm,
  input  logic              p1Req,
  input  logic [SET_W-1:0]  p1Set,
  input  logic              p1UseImm,
  input  logic [ADDR_W-1:0] p1Imm,
  output logic [ADDR_W-1:0] p0Addr,
  output logic              p0Valid,
  output logic [ADDR_W-1:0] p1Addr,
  output logic              p1Valid,
  output logic              conflict
);

  ctrlStb_t stb;

  circCtrl #(.SET_W(SET_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .p0Req(p0Req), .p0Set(p0Set), .p1Req(p1Req), .p1Set(p1Set),
    .stb(stb), .p0Valid(p0Valid), .p1Valid(p1Valid), .conflict(conflict)
  );

  circDatapath #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrKind(wrKind), .wrSet(wrSet), .wrData(wrData),
    .p0Set(p0Set), .p0UseImm(p0UseImm), .p0Imm(p0Imm),
    .p1Set(p1Set), .p1UseImm(p1UseImm), .p1Imm(p1Imm),
    .p0Addr(p0Addr), .p1Addr(p1Addr)
  );

endmodule

// File: rtl/circAddrGen_chk.sv
module circAddrGen_chk #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              p0Req,
  input logic [SET_W-1:0]  p0Set,
  input logic              p1Req,
  input logic [SET_W-1:0]  p1Set,
  input logic [ADDR_W-1:0] p0Addr,
  input logic              p0Valid,
  input logic [ADDR_W-1:0] p1Addr,
  input logic              p1Valid,
  input logic              conflict
);

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && p1Req) |=> (p0Valid && p1Valid)); // R3

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !p0Req |=> (!p0Valid && $stable(p0Addr))); // R3

  AST_CONFLICT_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (p0Req && p1Req && p0Set == p1Set) |=> conflict); // R9

  AST_CONFLICT_ONLY_ON_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(p0Req && p1Req && p0Set == p1Set) |=> !conflict); // R9

  AST_CLASH_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> (p0Addr == p1Addr && p0Valid && p1Valid)); // R9

endmodule

bind circAddrGen circAddrGen_chk #(.ADDR_W(ADDR_W), .SET_W(SET_W)) uChk (
  .clk(clk), .rstN(rstN), .p0Req(p0Req), .p0Set(p0Set), .p1Req(p1Req),
  .p1Set(p1Set), .p0Addr(p0Addr), .p0Valid(p0Valid), .p1Addr(p1Addr),
  .p1Valid(p1Valid), .conflict(conflict)
);

// File: tb/tb_circAddrGen.sv
`timescale 1ns/1ps
module tb_circAddrGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = '0;
  logic [1:0]  wrSet = '0;
  logic [31:0] wrData = '0;
  logic        p0Req = 1'b0, p1Req = 1'b0;
  logic [1:0]  p0Set = '0, p1Set = '0;
  logic        p0UseImm = 1'b0, p1UseImm = 1'b0;
  logic [31:0] p0Imm = '0, p1Imm = '0;
  logic [31:0] p0Addr, p1Addr;
  logic        p0Valid, p1Valid, conflict;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  circAddrGen dut (.*);

  typedef struct packed {
    logic        r0; logic [1:0] s0; logic i0; logic [31:0] m0;
    logic        r1; logic [1:0] s1; logic i1; logic [31:0] m1;
    logic [31:0] e0; logic [31:0] e1; logic ec;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 32'h0,  32'h100,  32'h2000, 1'b0},
    '{1'b1, 2'd0, 1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 32'h0,  32'h110,  32'h2004, 1'b0},
    '{1'b1, 2'd0, 1'b1, 32'h30,       1'b0, 2'd1, 1'b0, 32'h0,  32'h120,  32'h2004, 1'b0},
    '{1'b1, 2'd0, 1'b0, 32'h0,        1'b1, 2'd2, 1'b0, 32'h0,  32'h110,  32'h204,  1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h0,        1'b1, 2'd3, 1'b1, 32'h10, 32'h21C,  32'h320,  1'b0},
    '{1'b1, 2'd3, 1'b0, 32'h0,        1'b1, 2'd3, 1'b1, 32'h4,  32'h300,  32'h300,  1'b1},
    '{1'b1, 2'd3, 1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 32'h0,  32'h308,  32'h2008, 1'b0},
    '{1'b1, 2'd1, 1'b1, 32'hFFFFFFFC, 1'b0, 2'd0, 1'b0, 32'h0,  32'h200C, 32'h2008, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h0,        1'b1, 2'd0, 1'b0, 32'h0,  32'h2008, 32'h120,  1'b0}
  };

  function automatic string rowTag(input int n);
    case (n)
      0: return "R3 R4 R8";
      1: return "R4 R8";
      2: return "R5 R7 R3 hold";
      3: return "R6 R8";
      4: return "R5 boundary R7";
      5: return "R9 clash";
      6: return "R9 port0 wins";
      7: return "R4 negative R7";
      default: return "R4 R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] set, input logic [31:0] d);
    wrEn = 1'b1; wrKind = kind; wrSet = set; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle();
    p0Req = 1'b0; p1Req = 1'b0; p0UseImm = 1'b0; p1UseImm = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state at the outputs
    chk("R1 p0Addr", p0Addr, 32'h0);
    chk("R1 p1Addr", p1Addr, 32'h0);
    chk("R1 valid", {30'h0, p0Valid, p1Valid}, 32'h0);
    chk("R1 conflict", {31'h0, conflict}, 32'h0);
    // R1 registers cleared: set 2 index reads zero and stays zero
    p0Req = 1'b1; p0Set = 2'd2;
    @(negedge clk);
    chk("R1 index cleared", p0Addr, 32'h0);
    @(negedge clk);
    chk("R1 modify and length cleared", p0Addr, 32'h0);
    idle();
    @(negedge clk);

    // R2 load the four sets (kinds: 0 index,1 modify,2 length,3 base)
    wr(2'd3, 2'd0, 32'h100); wr(2'd2, 2'd0, 32'h40);
    wr(2'd0, 2'd0, 32'h100); wr(2'd1, 2'd0, 32'h10);
    wr(2'd2, 2'd1, 32'h0);   wr(2'd0, 2'd1, 32'h2000); wr(2'd1, 2'd1, 32'h4);
    wr(2'd3, 2'd2, 32'h200); wr(2'd2, 2'd2, 32'h20);
    wr(2'd0, 2'd2, 32'h204); wr(2'd1, 2'd2, 32'hFFFFFFF8);
    wr(2'd3, 2'd3, 32'h300); wr(2'd2, 2'd3, 32'h30);
    wr(2'd0, 2'd3, 32'h320); wr(2'd1, 2'd3, 32'h8);

    for (int n = 0; n < NV; n++) begin
      p0Req = TBL[n].r0; p0Set = TBL[n].s0; p0UseImm = TBL[n].i0; p0Imm = TBL[n].m0;
      p1Req = TBL[n].r1; p1Set = TBL[n].s1; p1UseImm = TBL[n].i1; p1Imm = TBL[n].m1;
      @(negedge clk);
      chk({rowTag(n), " p0Addr R2"}, p0Addr, TBL[n].e0);
      chk({rowTag(n), " p1Addr"}, p1Addr, TBL[n].e1);
      chk({rowTag(n), " p0Valid R3"}, {31'h0, p0Valid}, {31'h0, TBL[n].r0});
      chk({rowTag(n), " p1Valid R3"}, {31'h0, p1Valid}, {31'h0, TBL[n].r1});
      chk({rowTag(n), " conflict R9"}, {31'h0, conflict}, {31'h0, TBL[n].ec});
    end
    idle();
    @(negedge clk);
    chk("R3 no request valid low", {30'h0, p0Valid, p1Valid}, 32'h0);

    // R10: write index of set 0 at the same edge as a port 0 update
    p0Req = 1'b1; p0Set = 2'd0;
    wrEn = 1'b1; wrKind = 2'd0; wrSet = 2'd0; wrData = 32'h13C;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R10 old index output", p0Addr, 32'h130);
    @(negedge clk);
    chk("R10 write beats update", p0Addr, 32'h13C);
    @(negedge clk);
    chk("R5 wrap after write", p0Addr, 32'h10C);
    idle();

    // R4: linear step across the top of the address space
    wr(2'd0, 2'd1, 32'hFFFFFFFC);
    wr(2'd1, 2'd1, 32'h8);
    p1Req = 1'b1; p1Set = 2'd1;
    @(negedge clk);
    chk("R4 top of space", p1Addr, 32'hFFFFFFFC);
    @(negedge clk);
    chk("R4 wrap modulo 2^32", p1Addr, 32'h4);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule